// File: doc/BRIEF.md
# Unified Write-Through Set-Associative Cache

This block is a 4 KiB cache shared by instruction fetches and data accesses. It is looked up with virtual addresses. Its storage holds 256 lines of four 32-bit words. The lines form 4 sets, and each set has 64 ways. A core issues one request at a time on a valid/ready port. Each request carries an address, a direction, write data and two attributes. The first attribute, cacheable, lets the access use the cache. The second, updateable, lets a write refresh a cached copy.

A read that misses fetches the whole line from memory over a burst port. The line arrives as four word beats, lowest word first. The requested word is returned once the last beat has arrived. Every write is sent to memory through a separate single-word port, so memory always holds current data. A write does not allocate a line. A write that hits either refreshes the cached word or drops the line, depending on its updateable attribute.

The cache comes out of reset disabled and empty. An enable input turns lookups and allocation on, and a flush pulse invalidates every line at once. When a set has to give up a line, a free-running 6-bit pseudo-random sequence picks the way.

Top module: `ucache`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, mem_rd_valid and mem_wr_valid are 0. No line is valid, so the first cacheable read misses.
- R2: A cacheable read with the cache enabled looks up the set given by address bits [5:4] and compares the tag in bits [31:6]. On a hit it returns the word selected by bits [3:2], with rsp_valid high for exactly one cycle, two clock edges after acceptance, and with no memory read.
- R3: A read that does not hit issues one line read. The read address is the request address with bits [3:0] cleared, and it is held stable until mem_rd_ready. Memory then returns four beats for words 0 to 3 in order, and the response carries the requested word after the last beat.
- R4: A line filled by a cacheable read stays resident. Later reads of any word of that line hit, and lines in different sets do not disturb each other.
- R5: A read with cacheable=0 goes to memory and returns the memory word, and it allocates nothing. A later cacheable read of the same address still misses.
- R6: Every write appears once on the write port with its word address and data, held until mem_wr_ready. The response (rsp_valid, data 0) follows acceptance.
- R7: A cacheable write that hits with updateable=1 updates the cached word, so a following read hits and returns the new data.
- R8: A cacheable write that hits with updateable=0 invalidates the line, so the next read of that line misses.
- R9: A write that misses allocates no line.
- R10: A one-cycle cfg_flush pulse clears every valid bit, so every later read misses.
- R11: The victim way inside a set comes from a free-running 6-bit pseudo-random sequence that never holds zero. A set can take more distinct lines than it has ways, and each of them is fetched and returned correctly.
- R12: While cfg_enable is 0, reads neither hit nor allocate, but the stored lines are kept. When cfg_enable returns to 1 they hit again. The enable is registered, so a change applies to requests accepted at least two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Cache enable level |
| cfg_flush | input | 1 | One-cycle pulse that invalidates all lines |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Write word |
| req_cacheable | input | 1 | Access may use the cache |
| req_updateable | input | 1 | Write hit refreshes the cached word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read word (0 for writes) |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_ready | input | 1 | Memory accepts the line read |
| mem_rd_addr | output | 32 | Line-aligned read address |
| mem_rd_beat | input | 1 | A fill word is present |
| mem_rd_data | input | 32 | Fill word |
| mem_wr_valid | output | 1 | Write-through request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write word |

## Verification
The embedded properties run on every cycle. They check that:
- memory requests stay stable until they are accepted;
- the read and write ports are never busy together;
- responses are single pulses;
- at most one way matches in a set;
- a flush leaves no valid line;
- the victim sequence never reaches zero;
- only cacheable, enabled reads allocate.

Hit-or-miss outcomes, the returned data, and the effects of updateable, flush and disable can only be seen through the bench's scenarios. The bench compares fill and write counts and every response against a memory model.

// File: rtl/ucache_pkg.sv
package ucache_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_FILL_REQ,
      ST_FILL,
      ST_WRITE
   } ucache_state_e;

endpackage

// File: rtl/ucache_victim_ctr.sv
module ucache_victim_ctr #(
   parameter int WAY_W    = 6,
   parameter bit USE_LFSR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [WAY_W-1:0] victim
);

   logic [WAY_W-1:0] st_q;

   if (USE_LFSR && WAY_W == 6) begin : g_lfsr
      // maximal-length x^6 + x^5 + 1 sequence, period 63
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= 6'd1;
         else        st_q <= {st_q[4:0], st_q[5] ^ st_q[4]};
      end

      p_lfsr_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
         st_q != '0);
   end else begin : g_count
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st_q <= '0;
         else        st_q <= st_q + 1'b1;
      end
   end

   assign victim = st_q;

endmodule

// File: rtl/ucache_tag_store.sv
module ucache_tag_store #(
   parameter int SETS  = 4,
   parameter int WAYS  = 64,
   parameter int TAG_W = 26,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [SET_W-1:0] lk_set,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic [WAY_W-1:0] lk_way,
   input  logic             al_en,
   input  logic [SET_W-1:0] al_set,
   input  logic [WAY_W-1:0] al_way,
   input  logic [TAG_W-1:0] al_tag,
   input  logic             inv_en,
   input  logic [SET_W-1:0] inv_set,
   input  logic [WAY_W-1:0] inv_way
);

   logic [WAYS-1:0]  valid_q [SETS];
   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic [WAYS-1:0]  match;
   logic             any_valid;

   for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = valid_q[lk_set][g] && (tag_q[lk_set][g] == lk_tag);
   end

   always_comb begin
      lk_way = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (match[i]) lk_way = WAY_W'(i);
      end
   end
   assign lk_hit = |match;

   always_comb begin
      any_valid = 1'b0;
      for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end else if (flush) begin
         for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end else begin
         if (inv_en) valid_q[inv_set][inv_way] <= 1'b0;
         if (al_en)  valid_q[al_set][al_way]   <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (al_en) tag_q[al_set][al_way] <= al_tag;
   end

   p_unique_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));

   p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !any_valid);

endmodule

// File: rtl/ucache_data_store.sv
module ucache_data_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 1024,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_idx] <= wr_data;
   end

   assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/ucache.sv
module ucache
   import ucache_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int SETS       = 4,
   parameter int WAYS       = 64,
   parameter bit LFSR_PICK  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              cfg_flush,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_cacheable,
   input  logic              req_updateable,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_rd_valid,
   input  logic              mem_rd_ready,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_beat,
   input  logic [DATA_W-1:0] mem_rd_data,
   output logic              mem_wr_valid,
   input  logic              mem_wr_ready,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data
);

   localparam int BYTE_W   = $clog2(DATA_W / 8);
   localparam int WORD_W   = $clog2(LINE_WORDS);
   localparam int SET_W    = $clog2(SETS);
   localparam int WAY_W    = $clog2(WAYS);
   localparam int LINE_LSB = BYTE_W + WORD_W;
   localparam int TAG_W    = ADDR_W - SET_W - LINE_LSB;
   localparam int DEPTH    = SETS * WAYS * LINE_WORDS;
   localparam int IDX_W    = SET_W + WAY_W + WORD_W;
   localparam logic [WORD_W-1:0] BEAT_LAST = WORD_W'(LINE_WORDS - 1);

   if ((1 << WORD_W) != LINE_WORDS || LINE_WORDS < 2) begin : g_bad_line
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if ((1 << SET_W) != SETS || SETS < 2) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if ((1 << WAY_W) != WAYS || WAYS < 2) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes");
   end

   ucache_state_e     state_q;
   logic [ADDR_W-1:0] q_addr;
   logic [DATA_W-1:0] q_wdata;
   logic              q_wr, q_cch, q_upd, q_en, q_alloc, en_q;
   logic [WAY_W-1:0]  victim, victim_q;
   logic [WORD_W-1:0] beat_q;
   logic [DATA_W-1:0] cap_q, rsp_data_q;
   logic              rsp_valid_q;

   logic [SET_W-1:0]  a_set;
   logic [TAG_W-1:0]  a_tag;
   logic [WORD_W-1:0] a_word;
   logic              lk_hit;
   logic [WAY_W-1:0]  lk_way;
   logic              use_cache, rd_hit;
   logic              al_en, inv_en, dwr_en;
   logic [IDX_W-1:0]  dwr_idx, drd_idx;
   logic [DATA_W-1:0] dwr_data, drd_data;
   logic              in_lookup, in_fill, last_beat;

   assign a_set  = q_addr[LINE_LSB +: SET_W];
   assign a_tag  = q_addr[ADDR_W-1 -: TAG_W];
   assign a_word = q_addr[BYTE_W +: WORD_W];

   assign in_lookup = (state_q == ST_LOOKUP);
   assign in_fill   = (state_q == ST_FILL);
   assign last_beat = in_fill && mem_rd_beat && (beat_q == BEAT_LAST);
   assign use_cache = q_en && q_cch;
   assign rd_hit    = in_lookup && !q_wr && use_cache && lk_hit;

   ucache_victim_ctr #(
      .WAY_W    (WAY_W),
      .USE_LFSR (LFSR_PICK)
   ) u_victim (
      .clk    (clk),
      .rst_n  (rst_n),
      .victim (victim)
   );

   // line allocation only at the end of a cacheable fill
   assign al_en  = last_beat && q_alloc;
   // a non-updateable write hit drops the line to stay coherent
   assign inv_en = in_lookup && q_wr && q_cch && lk_hit && !q_upd;

   ucache_tag_store #(
      .SETS  (SETS),
      .WAYS  (WAYS),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (cfg_flush),
      .lk_set  (a_set),
      .lk_tag  (a_tag),
      .lk_hit  (lk_hit),
      .lk_way  (lk_way),
      .al_en   (al_en),
      .al_set  (a_set),
      .al_way  (victim_q),
      .al_tag  (a_tag),
      .inv_en  (inv_en),
      .inv_set (a_set),
      .inv_way (lk_way)
   );

   always_comb begin
      dwr_en   = 1'b0;
      dwr_idx  = {a_set, lk_way, a_word};
      dwr_data = q_wdata;
      if (in_fill && mem_rd_beat && q_alloc) begin
         dwr_en   = 1'b1;
         dwr_idx  = {a_set, victim_q, beat_q};
         dwr_data = mem_rd_data;
      end else if (in_lookup && q_wr && q_cch && lk_hit && q_upd) begin
         dwr_en = 1'b1;
      end
   end
   assign drd_idx = {a_set, lk_way, a_word};

   ucache_data_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_data (
      .clk     (clk),
      .wr_en   (dwr_en),
      .wr_idx  (dwr_idx),
      .wr_data (dwr_data),
      .rd_idx  (drd_idx),
      .rd_data (drd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         q_addr      <= '0;
         q_wdata     <= '0;
         q_wr        <= 1'b0;
         q_cch       <= 1'b0;
         q_upd       <= 1'b0;
         q_en        <= 1'b0;
         q_alloc     <= 1'b0;
         en_q        <= 1'b0;
         victim_q    <= '0;
         beat_q      <= '0;
         cap_q       <= '0;
         rsp_data_q  <= '0;
         rsp_valid_q <= 1'b0;
      end else begin
         en_q        <= cfg_enable;
         rsp_valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  q_addr  <= req_addr;
                  q_wdata <= req_wdata;
                  q_wr    <= req_write;
                  q_cch   <= req_cacheable;
                  q_upd   <= req_updateable;
                  q_en    <= en_q;
                  state_q <= ST_LOOKUP;
               end
            end
            ST_LOOKUP: begin
               if (q_wr) begin
                  state_q <= ST_WRITE;
               end else if (rd_hit) begin
                  rsp_valid_q <= 1'b1;
                  rsp_data_q  <= drd_data;
                  state_q     <= ST_IDLE;
               end else begin
                  victim_q <= victim;
                  q_alloc  <= use_cache;
                  state_q  <= ST_FILL_REQ;
               end
            end
            ST_FILL_REQ: begin
               if (mem_rd_ready) begin
                  beat_q  <= '0;
                  state_q <= ST_FILL;
               end
            end
            ST_FILL: begin
               if (mem_rd_beat) begin
                  if (beat_q == a_word) cap_q <= mem_rd_data;
                  beat_q <= beat_q + 1'b1;
                  if (beat_q == BEAT_LAST) begin
                     rsp_valid_q <= 1'b1;
                     rsp_data_q  <= (a_word == BEAT_LAST) ? mem_rd_data : cap_q;
                     q_alloc     <= 1'b0;
                     state_q     <= ST_IDLE;
                  end
               end
            end
            ST_WRITE: begin
               if (mem_wr_ready) begin
                  rsp_valid_q <= 1'b1;
                  rsp_data_q  <= '0;
                  state_q     <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (state_q == ST_IDLE);
   assign rsp_valid    = rsp_valid_q;
   assign rsp_rdata    = rsp_data_q;
   assign mem_rd_valid = (state_q == ST_FILL_REQ);
   assign mem_rd_addr  = {q_addr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
   assign mem_wr_valid = (state_q == ST_WRITE);
   assign mem_wr_addr  = {q_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
   assign mem_wr_data  = q_wdata;

   p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready) |=>
         (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

   p_ports_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_valid && mem_wr_valid));

   p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_rsp_when_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);

   p_hit_no_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> (rsp_valid && !mem_rd_valid));

   p_alloc_cacheable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      al_en |-> (q_en && q_cch && !q_wr));

endmodule

// File: tb/ucache_tb.sv
`timescale 1ns/1ps
module ucache_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b0, cfg_flush = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        req_cacheable = 1'b0, req_updateable = 1'b0;
   logic        req_ready, rsp_valid;
   logic [31:0] rsp_rdata;
   logic        mem_rd_valid, mem_wr_valid;
   logic        mem_rd_ready = 1'b0, mem_rd_beat = 1'b0, mem_wr_ready = 1'b0;
   logic [31:0] mem_rd_addr, mem_rd_data = '0, mem_wr_addr, mem_wr_data;

   always #4 clk = ~clk;

   ucache u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_flush(cfg_flush),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_cacheable(req_cacheable),
      .req_updateable(req_updateable), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
      .mem_rd_beat(mem_rd_beat), .mem_rd_data(mem_rd_data),
      .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
   );

   int checks = 0, errors = 0;
   int fill_cnt = 0, wr_cnt = 0;
   logic [31:0] last_rd_addr = '0, last_wr_addr = '0, last_wr_data = '0;
   logic [31:0] mem_model [logic [29:0]];

   logic [31:0] exp_q [$];
   bit          chk_q [$];
   string       req_q [$];

   function automatic logic [31:0] model_rd(input logic [31:0] a);
      if (mem_model.exists(a[31:2])) return mem_model[a[31:2]];
      return a ^ 32'h5A5A_C3C3;
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // memory line-read responder
   initial begin
      forever begin
         @(negedge clk);
         if (mem_rd_valid) begin
            logic [31:0] line;
            line = mem_rd_addr;
            last_rd_addr = line;
            fill_cnt++;
            mem_rd_ready = 1'b1;
            @(negedge clk);
            mem_rd_ready = 1'b0;
            for (int b = 0; b < 4; b++) begin
               mem_rd_beat = 1'b1;
               mem_rd_data = model_rd({line[31:4], 4'h0} + 32'(b * 4));
               @(negedge clk);
            end
            mem_rd_beat = 1'b0;
         end
      end
   end

   // memory write responder
   initial begin
      forever begin
         @(negedge clk);
         if (mem_wr_valid) begin
            mem_wr_ready = 1'b1;
            last_wr_addr = mem_wr_addr;
            last_wr_data = mem_wr_data;
            mem_model[mem_wr_addr[31:2]] = mem_wr_data;
            wr_cnt++;
            @(negedge clk);
            mem_wr_ready = 1'b0;
         end
      end
   end

   // response monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2", "unexpected response", rsp_rdata, 32'h0);
            end else begin
               logic [31:0] e;
               bit c;
               string r;
               e = exp_q.pop_front();
               c = chk_q.pop_front();
               r = req_q.pop_front();
               if (c) check(rsp_rdata == e, r, "read data", rsp_rdata, e);
            end
         end
      end
   end

   task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                         input bit cch, input bit upd, input int exp_fill,
                         input string rq);
      int f0, w0;
      f0 = fill_cnt;
      w0 = wr_cnt;
      exp_q.push_back(wr ? 32'h0 : model_rd(a));
      chk_q.push_back(!wr);
      req_q.push_back(rq);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      req_cacheable = cch; req_updateable = upd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      check(fill_cnt - f0 == exp_fill, rq, "line fills",
            32'(fill_cnt - f0), 32'(exp_fill));
      if (exp_fill > 0)
         check(last_rd_addr == {a[31:4], 4'h0}, "R3", "fill address",
               last_rd_addr, {a[31:4], 4'h0});
      if (wr) begin
         check(wr_cnt - w0 == 1, "R6", "write-through count", 32'(wr_cnt - w0), 32'd1);
         check(last_wr_addr == {a[31:2], 2'b00}, "R6", "write address",
               last_wr_addr, {a[31:2], 2'b00});
         check(last_wr_data == d, "R6", "write data", last_wr_data, d);
      end else begin
         check(wr_cnt == w0, "R6", "no write on read", 32'(wr_cnt - w0), 32'd0);
      end
   endtask

   task automatic set_enable(input bit en);
      @(negedge clk);
      cfg_enable = en;
      repeat (3) @(negedge clk);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   localparam logic [31:0] A = 32'h1000_0024; // set 2, word 1
   localparam logic [31:0] C = 32'h1000_0010; // set 1
   localparam logic [31:0] D = 32'h3000_0008; // set 0
   localparam logic [31:0] E = 32'h4000_0030; // set 3

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
      check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
      check(mem_rd_valid == 1'b0 && mem_wr_valid == 1'b0, "R1", "memory ports idle",
            32'({mem_rd_valid, mem_wr_valid}), 32'd0);
      rst_n = 1'b1;
      set_enable(1'b1);

      access(0, A, 0, 1, 0, 1, "R1");          // empty cache: miss
      access(0, A, 0, 1, 0, 0, "R2");          // hit
      access(0, A + 4, 0, 1, 0, 0, "R2");      // other word, same line
      access(0, A - 4, 0, 1, 0, 0, "R4");      // word 0
      access(0, A + 8, 0, 1, 0, 0, "R4");      // word 3
      access(0, C, 0, 1, 0, 1, "R3");          // other set: miss
      access(0, A, 0, 1, 0, 0, "R4");          // A unaffected
      access(0, C + 12, 0, 1, 0, 0, "R4");

      // R5: non-cacheable reads bypass and do not allocate
      access(0, D, 0, 0, 0, 1, "R5");
      access(0, D, 0, 0, 0, 1, "R5");
      access(0, D, 0, 1, 0, 1, "R5");
      access(0, D, 0, 1, 0, 0, "R5");

      // R7: updateable write hit refreshes cache
      access(1, A, 32'hCAFE_0001, 1, 1, 0, "R7");
      access(0, A, 0, 1, 0, 0, "R7");
      // R8: non-updateable write hit drops the line
      access(1, A, 32'hCAFE_0002, 1, 0, 0, "R8");
      access(0, A, 0, 1, 0, 1, "R8");
      access(0, A, 0, 1, 0, 0, "R8");
      // R9: write miss does not allocate
      access(1, E, 32'hBEEF_0003, 1, 1, 0, "R9");
      access(0, E, 0, 1, 0, 1, "R9");

      // R10: flush
      @(negedge clk); cfg_flush = 1'b1;
      @(negedge clk); cfg_flush = 1'b0;
      access(0, A, 0, 1, 0, 1, "R10");
      access(0, C, 0, 1, 0, 1, "R10");
      access(0, E, 0, 1, 0, 1, "R10");

      // R12: disable keeps lines but stops hits
      set_enable(1'b0);
      access(0, A, 0, 1, 0, 1, "R12");
      access(0, A, 0, 1, 0, 1, "R12");
      set_enable(1'b1);
      access(0, A, 0, 1, 0, 0, "R12");

      // R11: more distinct lines in one set than ways
      for (int i = 0; i < 70; i++) begin
         logic [31:0] a;
         a = {6'(i + 8), 20'h0, 2'b00, 4'h4};
         access(0, a, 0, 1, 0, 1, "R11");
         access(0, a, 0, 1, 0, 0, "R11");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule